// File: doc/BRIEF.md
# Serial Converter Control-Word Front End

This block is the digital side of a two-channel serial converter. A host lowers chip select and clocks sixteen bits into the data input, most significant bit first. During the same transfer the block sends the previous conversion result out on the data output. When chip select rises after exactly sixteen serial clocks, the block inspects the top bit of the received word. If that bit is 0, the word passes through with no effect on this stage, which lets several converters share one daisy chain. If that bit is 1, the word is latched as the new configuration and a conversion starts.

A small state machine tracks four states: `ST_IDLE`, `ST_CONV`, `ST_PDOWN` and `ST_STALL`. A conversion timer counts oscillator-enabled cycles. When it expires, a placeholder generator writes the selected channel and a running sequence number into the result register. A word that stops the oscillator leads to a stalled state: the next applied word drops BUSY, and BUSY stays low until a pass-through word resets the machine.

Transitions:
- `ST_IDLE`/`ST_CONV` → `ST_CONV` on an applied word with the oscillator-stop bit clear.
- `ST_IDLE`/`ST_CONV` → `ST_PDOWN` on an applied word with that bit set.
- `ST_CONV` → `ST_IDLE` when the timer expires.
- `ST_PDOWN`/`ST_STALL` → `ST_STALL` on any applied word.
- any state → `ST_IDLE` on a pass-through word.

The serial clock and chip select are sampled in the system clock domain. Data input is taken on a rising serial-clock edge, and the data output moves on a falling edge.

Top module: `sadc_ctrl_top`

## Requirements
- R1: Each complete transfer returns the result register as it stood when chip select fell, MSB first. The data output changes only on falling serial-clock edges, and the data input is sampled on rising edges.
- R2: After reset the configuration and result are zero, busy is high, osc_en is high, and the first transfer reads 0x0000.
- R3: A word with bit 15 = 0 leaves chan_sel and pwr_down unchanged and starts no conversion (the result stays the same). It returns the machine to idle, with busy high and osc_en high, and bits 14..0 have no effect.
- R4: A word with bit 15 = 1 received in idle with bit 1 = 0 latches the configuration and drives busy low on chip-select rise.
- R5: A conversion keeps busy low for CONV_CYCLES (default 64) system-clock cycles. Busy then rises and the result register loads.
- R6: A result holds the channel select in bit 15 and a 15-bit sequence number in bits 14..0. The sequence number starts at 0 after reset and increases by one per completed conversion.
- R7: chan_sel follows bit 4 of the last applied word (1 = input pair 2), and pwr_down follows bit 0.
- R8: An applied word with bit 1 = 1 drives osc_en low, keeps busy high and starts no conversion.
- R9: An applied word (bit 15 = 1) that arrives while the oscillator is stopped drives busy low. Busy and osc_en then stay low for as long as no further word arrives.
- R10: A word with bit 15 = 0 clears the stalled condition, leaving busy high and osc_en high, and the next applied word converts normally.
- R11: A transfer that does not contain exactly 16 serial clocks is discarded: configuration, busy and result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the conversion oscillator |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial control-word input |
| dout | output | 1 | Serial result output (0 while deselected) |
| busy | output | 1 | Low while a conversion runs or is stalled |
| chan_sel | output | 1 | Selected input pair (0 = pair 1, 1 = pair 2) |
| pwr_down | output | 1 | Analog power-down request |
| osc_en | output | 1 | Conversion oscillator enable |

## Verification
The bench tracks the result one transfer late: the first read must be zero, and each later read must carry the previous channel and sequence number. A design that returned the current result, or that counted pass-through words as conversions, would read back the wrong sequence. A pass-through word whose low bits would change every field is sent, and a design that latched it would show new chan_sel or pwr_down levels or a stale result later. The oscillator-stop sequence is held for hundreds of cycles to catch a stalled BUSY that recovers by itself, and it is then cleared with a pass-through word. A fifteen-clock transfer checks that a short frame is not applied.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
    localparam int BIT_NOP = 15;
    localparam int BIT_CHS = 4;
    localparam int BIT_PDX = 1;
    localparam int BIT_PD  = 0;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONV,
        ST_PDOWN,
        ST_STALL
    } conv_state_e;

    typedef struct packed {
        logic chs;
        logic pdx;
        logic pd;
    } cfg_t;
endpackage

// File: rtl/sadc_shifter.sv
module sadc_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk,
    input  logic         cs_n,
    input  logic         din,
    input  logic [W-1:0] load_data,
    output logic         dout,
    output logic         word_vld,
    output logic [W-1:0] word
);
    localparam int CNT_W = $clog2(W + 2) + 1;

    logic sclk_s1, sclk_s2, cs_s1, cs_s2, din_s1;
    logic [W-1:0] in_sh, out_sh;
    logic [CNT_W-1:0] bit_cnt;
    logic sck_rise, sck_fall, cs_fall, cs_rise;

    assign sck_rise = sclk_s1 & ~sclk_s2;
    assign sck_fall = ~sclk_s1 & sclk_s2;
    assign cs_fall  = ~cs_s1 & cs_s2;
    assign cs_rise  = cs_s1 & ~cs_s2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_s1 <= 1'b0;
            sclk_s2 <= 1'b0;
            cs_s1   <= 1'b1;
            cs_s2   <= 1'b1;
            din_s1  <= 1'b0;
        end else begin
            sclk_s1 <= sclk;
            sclk_s2 <= sclk_s1;
            cs_s1   <= cs_n;
            cs_s2   <= cs_s1;
            din_s1  <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_sh    <= '0;
            out_sh   <= '0;
            bit_cnt  <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= cs_rise && (bit_cnt == CNT_W'(W));
            if (cs_fall) begin
                out_sh  <= load_data;
                bit_cnt <= '0;
            end else if (!cs_s1) begin
                if (sck_rise) begin
                    in_sh <= {in_sh[W-2:0], din_s1};
                    if (bit_cnt <= CNT_W'(W))
                        bit_cnt <= bit_cnt + 1'b1;
                end
                if (sck_fall)
                    out_sh <= {out_sh[W-2:0], 1'b0};
            end
        end
    end

    assign dout = ~cs_s1 & out_sh[W-1];
    assign word = in_sh;
endmodule

// File: rtl/sadc_conv_fsm.sv
module sadc_conv_fsm
    import sadc_pkg::*;
#(
    parameter int CONV_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic word_vld,
    input  logic w_nop,
    input  cfg_t w_cfg,
    output cfg_t cfg,
    output logic busy,
    output logic osc_en,
    output logic done
);
    localparam int TMR_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(CONV_CYCLES - 1);

    conv_state_e state, nxt;
    logic [TMR_W-1:0] tmr;
    logic start, load;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state and transition strobes
    always_comb begin
        nxt   = state;
        start = 1'b0;
        load  = 1'b0;
        done  = 1'b0;
        unique case (state)
            ST_IDLE, ST_CONV: begin
                if (word_vld) begin
                    if (w_nop) begin
                        load = 1'b1;
                        if (w_cfg.pdx) begin
                            nxt = ST_PDOWN;
                        end else begin
                            nxt   = ST_CONV;
                            start = 1'b1;
                        end
                    end else begin
                        nxt = ST_IDLE;
                    end
                end else if (state == ST_CONV && tmr == TMR_LAST) begin
                    nxt  = ST_IDLE;
                    done = 1'b1;
                end
            end
            ST_PDOWN, ST_STALL: begin
                if (word_vld) begin
                    if (w_nop) begin
                        load = 1'b1;
                        nxt  = ST_STALL;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy   = !(state == ST_CONV || state == ST_STALL);
        osc_en = !(state == ST_PDOWN || state == ST_STALL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
            tmr <= '0;
        end else begin
            if (load)
                cfg <= w_cfg;
            if (start)
                tmr <= '0;
            else if (state == ST_CONV && osc_en)
                tmr <= tmr + 1'b1;
        end
    end
endmodule

// File: rtl/sadc_result_gen.sv
module sadc_result_gen #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         done,
    input  logic         chs,
    output logic [W-1:0] result
);
    localparam int SEQ_W = W - 1;

    logic [SEQ_W-1:0] seq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq    <= '0;
            result <= '0;
        end else if (done) begin
            result <= {chs, seq};
            seq    <= seq + 1'b1;
        end
    end
endmodule

// File: rtl/sadc_ctrl_top.sv
module sadc_ctrl_top
    import sadc_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int CONV_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic din,
    output logic dout,
    output logic busy,
    output logic chan_sel,
    output logic pwr_down,
    output logic osc_en
);
    logic [WORD_W-1:0] rx_word, result_q;
    logic word_vld, conv_done;
    cfg_t w_cfg, cfg_q;
    logic unused_bits;

    assign w_cfg.chs   = rx_word[BIT_CHS];
    assign w_cfg.pdx   = rx_word[BIT_PDX];
    assign w_cfg.pd    = rx_word[BIT_PD];
    assign unused_bits = ^{rx_word[14:5], rx_word[3:2]};

    sadc_shifter #(.W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .din       (din),
        .load_data (result_q),
        .dout      (dout),
        .word_vld  (word_vld),
        .word      (rx_word)
    );

    sadc_conv_fsm #(.CONV_CYCLES(CONV_CYCLES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_vld (word_vld),
        .w_nop    (rx_word[BIT_NOP]),
        .w_cfg    (w_cfg),
        .cfg      (cfg_q),
        .busy     (busy),
        .osc_en   (osc_en),
        .done     (conv_done)
    );

    sadc_result_gen #(.W(WORD_W)) u_res (
        .clk    (clk),
        .rst_n  (rst_n),
        .done   (conv_done),
        .chs    (cfg_q.chs),
        .result (result_q)
    );

    assign chan_sel = cfg_q.chs;
    assign pwr_down = cfg_q.pd;
endmodule

// File: rtl/sadc_ctrl_chk.sv
module sadc_ctrl_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         word_vld,
    input logic         w_nop,
    input logic         w_chs,
    input logic         w_pdx,
    input logic         busy,
    input logic         osc_en,
    input logic         chan_sel,
    input logic         pwr_down,
    input logic [W-1:0] result
);
    a_r3_passthru_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && !w_nop) |=> (busy && osc_en && $stable(chan_sel) && $stable(pwr_down)));

    a_r4_start_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && w_nop && !w_pdx && busy && osc_en) |=> (!busy && chan_sel == $past(w_chs)));

    a_r6_result_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> $rose(busy));

    a_r8_osc_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && w_nop && w_pdx && busy && osc_en) |=> (busy && !osc_en));

    a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !osc_en && !word_vld) |=> (!busy && !osc_en));
endmodule

bind sadc_ctrl_top sadc_ctrl_chk #(.W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_vld (word_vld),
    .w_nop    (rx_word[15]),
    .w_chs    (rx_word[4]),
    .w_pdx    (rx_word[1]),
    .busy     (busy),
    .osc_en   (osc_en),
    .chan_sel (chan_sel),
    .pwr_down (pwr_down),
    .result   (result_q)
);

// File: tb/sadc_ctrl_tb.sv
module sadc_ctrl_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic din = 1'b0;
    logic dout, busy, chan_sel, pwr_down, osc_en;
    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;
    logic [15:0] rd;

    always #2.5 clk = ~clk;

    sadc_ctrl_top #(.WORD_W(16), .CONV_CYCLES(64)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
        .dout(dout), .busy(busy), .chan_sel(chan_sel), .pwr_down(pwr_down),
        .osc_en(osc_en)
    );

    function automatic logic [15:0] mk(logic nop, logic chs, logic pdx, logic pd);
        return {nop, 10'b0, chs, 2'b00, pdx, pd};
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [15:0] w, input int nbits, output logic [15:0] r);
        @(negedge clk) cs_n = 1'b0;
        repeat (4) @(negedge clk);
        r = '0;
        for (int i = 0; i < nbits; i++) begin
            din = w[15-i];
            repeat (3) @(negedge clk);
            r = {r[14:0], dout};
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    // Conversion started a few cycles before; still low mid-way, high after CONV_CYCLES
    task automatic wait_conv(string req);
        repeat (44) @(negedge clk);
        chk({req, " busy low mid-conversion"}, {15'b0, busy}, 16'h0000);
        repeat (30) @(negedge clk);
        chk({req, " busy high after conversion"}, {15'b0, busy}, 16'h0001);
    endtask

    task automatic t_reset();
        chk("R2 busy after reset", {15'b0, busy}, 16'h0001);
        chk("R2 osc_en after reset", {15'b0, osc_en}, 16'h0001);
        chk("R2 chan_sel after reset", {15'b0, chan_sel}, 16'h0000);
        chk("R2 pwr_down after reset", {15'b0, pwr_down}, 16'h0000);
    endtask

    task automatic t_first_and_order();
        xfer(mk(1, 1, 0, 0), 16, rd);
        chk("R2 first readout zero", rd, 16'h0000);
        chk("R4 busy low after start", {15'b0, busy}, 16'h0000);
        chk("R7 chan_sel pair 2", {15'b0, chan_sel}, 16'h0001);
        wait_conv("R5");
        xfer(mk(1, 0, 0, 1), 16, rd);
        chk("R1 R6 previous result ch1 seq0", rd, 16'h8000);
        chk("R7 chan_sel pair 1", {15'b0, chan_sel}, 16'h0000);
        chk("R7 pwr_down set", {15'b0, pwr_down}, 16'h0001);
        wait_conv("R5");
    endtask

    task automatic t_passthru();
        xfer(16'h7FFF, 16, rd);
        chk("R6 result ch0 seq1", rd, 16'h0001);
        chk("R3 chan_sel unchanged", {15'b0, chan_sel}, 16'h0000);
        chk("R3 pwr_down unchanged", {15'b0, pwr_down}, 16'h0001);
        chk("R3 no conversion busy", {15'b0, busy}, 16'h0001);
        repeat (80) @(negedge clk);
        xfer(mk(1, 1, 0, 0), 16, rd);
        chk("R3 result unchanged", rd, 16'h0001);
        chk("R7 pwr_down cleared", {15'b0, pwr_down}, 16'h0000);
        wait_conv("R5");
    endtask

    task automatic t_short();
        xfer(mk(1, 0, 0, 1), 15, rd);
        chk("R11 chan_sel kept", {15'b0, chan_sel}, 16'h0001);
        chk("R11 pwr_down kept", {15'b0, pwr_down}, 16'h0000);
        chk("R11 busy kept", {15'b0, busy}, 16'h0001);
        repeat (80) @(negedge clk);
        xfer(mk(1, 1, 0, 0), 16, rd);
        chk("R11 R1 result unchanged", rd, 16'h8002);
        wait_conv("R5");
    endtask

    task automatic t_stall();
        xfer(mk(1, 1, 1, 0), 16, rd);
        chk("R1 result ch2 seq3", rd, 16'h8003);
        chk("R8 busy stays high", {15'b0, busy}, 16'h0001);
        chk("R8 osc_en low", {15'b0, osc_en}, 16'h0000);
        repeat (80) @(negedge clk);
        chk("R8 no conversion", {15'b0, busy}, 16'h0001);
        xfer(mk(1, 0, 0, 0), 16, rd);
        chk("R8 result unchanged", rd, 16'h8003);
        chk("R9 busy low", {15'b0, busy}, 16'h0000);
        repeat (300) @(negedge clk);
        chk("R9 busy still low", {15'b0, busy}, 16'h0000);
        chk("R9 osc_en still low", {15'b0, osc_en}, 16'h0000);
        xfer(16'h0013, 16, rd);
        chk("R9 result unchanged during stall", rd, 16'h8003);
        chk("R10 busy high", {15'b0, busy}, 16'h0001);
        chk("R10 osc_en high", {15'b0, osc_en}, 16'h0001);
        xfer(mk(1, 1, 0, 0), 16, rd);
        chk("R10 busy low on new start", {15'b0, busy}, 16'h0000);
        wait_conv("R10");
        xfer(16'h0000, 16, rd);
        chk("R10 R6 result ch2 seq4", rd, 16'h8004);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_first_and_order();
        t_passthru();
        t_short();
        t_stall();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule